// File: doc/BRIEF.md
# JTAG Debug Register Access Port

This block is the target side of a JTAG test access port. A debug host uses it to reach a bank of 32-bit debug registers that sit on an internal register bus, and two 8-bit power registers. The power registers are a control byte that the host writes and a status byte of sticky event bits that the host clears. The port contains the complete sixteen-state TAP controller, a 5-bit instruction register with its decoder, a bypass bit, an identification register, and a simple strobed request interface toward the debug register bank.

A debug register access uses one instruction and two data scans in a row. The first scan is 8 bits long. It names a register and says whether the access is a read or a write. The second scan is 32 bits long and carries the data. For a write, the data goes to the register. For a read, the register value comes back to the host. A phase flag inside the port keeps track of which of the two scans comes next. All logic runs on TCK. The registers behind the bus are outside the block.

Top module: `dbg_jtag_port`

## Requirements
- R1: Driving trstN low, or five rising TCK edges with TMS high, puts the controller in Test-Logic-Reset. Test-Logic-Reset loads the identification opcode 0x1E into the instruction register.
- R2: The instruction register is 5 bits wide and is shifted LSB first. Capture-IR loads the pattern 5'b00001, so the first bit out on TDO is 1.
- R3: Under opcode 0x1E, a 32-bit data scan shifts out the IDCODE parameter, LSB first.
- R4: Opcode 0x1F, and every opcode that is not assigned, selects a 1-bit bypass stage. That stage captures 0, so an 8-bit scan of value v returns {v[6:0],0}.
- R5: Under opcode 0x1C, the first data scan is 8 bits. Bits 7:1 hold the register number and bit 0 is the direction: 1 means write, 0 means read. For a read, busStb is high for one cycle with busWe=0 and busAddr equal to the register number. This happens in the TCK cycle that follows Update-DR.
- R6: For a write, the second data scan is 32 bits. In the cycle after its Update-DR, busStb and busWe are both 1, busAddr holds the register number and busWdata holds the shifted-in value.
- R7: For a read, the second 32-bit scan shifts out the busRdata value that was captured in its Capture-DR, LSB first. The bits shifted in during that scan are ignored, and no bus write is issued.
- R8: The phase flag toggles at every Update-DR while opcode 0x1C is held. Loading an instruction resets the flag to the address phase.
- R9: Opcode 0x08 selects an 8-bit power-control scan. The scan captures the current pwrCtl, and pwrCtl takes the shifted-in value on the edge that leaves Update-DR. pwrCtl is 0 after reset.
- R10: Opcode 0x09 selects an 8-bit power-status scan. A pwrEvent bit sets the matching sticky status bit. The scan shifts out the sticky bits, and at Update-DR the bits that are 1 in the shifted-in value are cleared.
- R11: TDO changes on the falling edge of TCK. It is 0 outside Shift-IR and Shift-DR.
- R12: busStb is a single-cycle pulse. It is raised only in the cycle after an Update-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| pwrEvent | input | PWR_W | Sets the sticky power status bits |
| pwrCtl | output | PWR_W | Power control byte |
| busStb | output | 1 | Register bus request strobe |
| busWe | output | 1 | Register bus write enable |
| busAddr | output | ADDR_W | Register bus address |
| busWdata | output | DATA_W | Register bus write data |
| busRdata | input | DATA_W | Register bus read data, sampled in Capture-DR of the data phase |

## Verification
Each TDO bit is valid 1 ns after the falling edge of every Shift-state cycle, and the bench reads it at exactly that point before it drives the next TMS/TDI pair. Bus strobes and pwrCtl change on the rising edge that leaves Update-DR. The bench therefore samples them just after the next falling edge, and one cycle later it confirms that the strobe has dropped. Read data is captured in Capture-DR of the data phase. The bench's register model keeps busRdata valid from the read strobe onward, so the value shifted out is compared with the model's expected array.

// File: rtl/dbg_jtag_pkg.sv
package dbg_jtag_pkg;
  localparam int IR_W = 5;
  localparam logic [IR_W-1:0] OP_PWRCTL  = 5'h08;
  localparam logic [IR_W-1:0] OP_PWRSTAT = 5'h09;
  localparam logic [IR_W-1:0] OP_REGSEL  = 5'h1C;
  localparam logic [IR_W-1:0] OP_IDCODE  = 5'h1E;
  localparam logic [IR_W-1:0] OP_BYPASS  = 5'h1F;
  localparam logic [IR_W-1:0] IR_CAPTURE = 5'b00001;

  typedef enum logic [3:0] {
    stTlr, stRti, stSelDr, stCapDr, stShDr, stEx1Dr, stPsDr, stEx2Dr, stUpDr,
    stSelIr, stCapIr, stShIr, stEx1Ir, stPsIr, stEx2Ir, stUpIr
  } tapState_e;

  typedef enum logic [2:0] {
    selBypass, selIdcode, selPwrCtl, selPwrStat, selRegAddr, selRegData
  } drSel_e;

  typedef struct packed {
    logic   captureDr;
    logic   shiftDr;
    logic   updateDr;
    logic   shiftIr;
    logic   irTdo;
    drSel_e sel;
  } tapStrobe_t;
endpackage

// File: rtl/dbg_tap_ctrl.sv
module dbg_tap_ctrl
  import dbg_jtag_pkg::*;
(
  input  logic             tck,
  input  logic             trstN,
  input  logic             tms,
  input  logic             tdi,
  output tapStrobe_t       strb,
  output tapState_e        stateOut,
  output logic             phaseOut,
  output logic [IR_W-1:0]  irOut
);
  tapState_e       state, stateNext;
  logic [IR_W-1:0] irShift, irHold;
  logic            phaseData;

  always_comb begin
    unique case (state)
      stTlr:   stateNext = tms ? stTlr   : stRti;
      stRti:   stateNext = tms ? stSelDr : stRti;
      stSelDr: stateNext = tms ? stSelIr : stCapDr;
      stCapDr: stateNext = tms ? stEx1Dr : stShDr;
      stShDr:  stateNext = tms ? stEx1Dr : stShDr;
      stEx1Dr: stateNext = tms ? stUpDr  : stPsDr;
      stPsDr:  stateNext = tms ? stEx2Dr : stPsDr;
      stEx2Dr: stateNext = tms ? stUpDr  : stShDr;
      stUpDr:  stateNext = tms ? stSelDr : stRti;
      stSelIr: stateNext = tms ? stTlr   : stCapIr;
      stCapIr: stateNext = tms ? stEx1Ir : stShIr;
      stShIr:  stateNext = tms ? stEx1Ir : stShIr;
      stEx1Ir: stateNext = tms ? stUpIr  : stPsIr;
      stPsIr:  stateNext = tms ? stEx2Ir : stPsIr;
      stEx2Ir: stateNext = tms ? stUpIr  : stShIr;
      default: stateNext = tms ? stSelDr : stRti;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      state     <= stTlr;
      irShift   <= IR_CAPTURE;
      irHold    <= OP_IDCODE;
      phaseData <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == stCapIr)     irShift <= IR_CAPTURE;
      else if (state == stShIr) irShift <= {tdi, irShift[IR_W-1:1]};
      if (state == stTlr) begin
        irHold    <= OP_IDCODE;
        phaseData <= 1'b0;
      end else if (state == stUpIr) begin
        irHold    <= irShift;
        phaseData <= 1'b0;
      end else if (state == stUpDr && irHold == OP_REGSEL) begin
        phaseData <= ~phaseData;
      end
    end
  end

  always_comb begin
    strb.captureDr = (state == stCapDr);
    strb.shiftDr   = (state == stShDr);
    strb.updateDr  = (state == stUpDr);
    strb.shiftIr   = (state == stShIr);
    strb.irTdo     = irShift[0];
    unique case (irHold)
      OP_IDCODE:  strb.sel = selIdcode;
      OP_PWRCTL:  strb.sel = selPwrCtl;
      OP_PWRSTAT: strb.sel = selPwrStat;
      OP_REGSEL:  strb.sel = phaseData ? selRegData : selRegAddr;
      default:    strb.sel = selBypass;
    endcase
  end

  assign stateOut = state;
  assign phaseOut = phaseData;
  assign irOut    = irHold;
endmodule

// File: rtl/dbg_tap_dp.sv
module dbg_tap_dp
  import dbg_jtag_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter int          ADDR_W = 7,
  parameter int          PWR_W  = 8,
  parameter logic [31:0] IDCODE = 32'h10DE_5A03
) (
  input  logic              tck,
  input  logic              trstN,
  input  logic              tdi,
  input  tapStrobe_t        strb,
  input  logic [PWR_W-1:0]  pwrEvent,
  input  logic [DATA_W-1:0] busRdata,
  output logic              tdo,
  output logic [PWR_W-1:0]  pwrCtl,
  output logic              busStb,
  output logic              busWe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata
);
  localparam int ID_W  = 32;
  localparam int SEL_W = ADDR_W + 1;
  localparam int M1    = (DATA_W > ID_W) ? DATA_W : ID_W;
  localparam int M2    = (SEL_W > PWR_W) ? SEL_W : PWR_W;
  localparam int SR_W  = (M1 > M2) ? M1 : M2;

  logic [SR_W-1:0]   shiftReg, shiftNext, captureVal;
  logic [PWR_W-1:0]  pwrStat, statNext;
  logic [ADDR_W-1:0] addrReg;
  logic              wrFlag;
  int                drLen;

  always_comb begin
    unique case (strb.sel)
      selIdcode:  drLen = ID_W;
      selPwrCtl:  drLen = PWR_W;
      selPwrStat: drLen = PWR_W;
      selRegAddr: drLen = SEL_W;
      selRegData: drLen = DATA_W;
      default:    drLen = 1;
    endcase
    shiftNext = shiftReg >> 1;
    shiftNext[drLen-1] = tdi;
    unique case (strb.sel)
      selIdcode:  captureVal = SR_W'(IDCODE);
      selPwrCtl:  captureVal = SR_W'(pwrCtl);
      selPwrStat: captureVal = SR_W'(pwrStat);
      selRegAddr: captureVal = SR_W'({addrReg, wrFlag});
      selRegData: captureVal = SR_W'(busRdata);
      default:    captureVal = '0;
    endcase
    statNext = pwrStat;
    if (strb.updateDr && strb.sel == selPwrStat) statNext = statNext & ~shiftReg[PWR_W-1:0];
    statNext = statNext | pwrEvent;
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      shiftReg <= '0;
      pwrCtl   <= '0;
      pwrStat  <= '0;
      addrReg  <= '0;
      wrFlag   <= 1'b0;
      busStb   <= 1'b0;
      busWe    <= 1'b0;
      busWdata <= '0;
    end else begin
      busStb  <= 1'b0;
      busWe   <= 1'b0;
      pwrStat <= statNext;
      if (strb.captureDr)    shiftReg <= captureVal;
      else if (strb.shiftDr) shiftReg <= shiftNext;
      if (strb.updateDr) begin
        unique case (strb.sel)
          selPwrCtl: pwrCtl <= shiftReg[PWR_W-1:0];
          selRegAddr: begin
            addrReg <= shiftReg[ADDR_W:1];
            wrFlag  <= shiftReg[0];
            busStb  <= ~shiftReg[0];
          end
          selRegData: if (wrFlag) begin
            busStb   <= 1'b1;
            busWe    <= 1'b1;
            busWdata <= shiftReg[DATA_W-1:0];
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN)            tdo <= 1'b0;
    else if (strb.shiftDr) tdo <= shiftReg[0];
    else if (strb.shiftIr) tdo <= strb.irTdo;
    else                   tdo <= 1'b0;
  end

  assign busAddr = addrReg;
endmodule

// File: rtl/dbg_jtag_port.sv
module dbg_jtag_port
  import dbg_jtag_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter int          ADDR_W = 7,
  parameter int          PWR_W  = 8,
  parameter logic [31:0] IDCODE = 32'h10DE_5A03
) (
  input  logic              tck,
  input  logic              trstN,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  input  logic [PWR_W-1:0]  pwrEvent,
  output logic [PWR_W-1:0]  pwrCtl,
  output logic              busStb,
  output logic              busWe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata
);
  tapStrobe_t      strb;
  tapState_e       tapState;
  logic            phaseData;
  logic [IR_W-1:0] irHold;

  dbg_tap_ctrl i_ctrl (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi),
    .strb(strb), .stateOut(tapState), .phaseOut(phaseData), .irOut(irHold)
  );

  dbg_tap_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PWR_W(PWR_W), .IDCODE(IDCODE)) i_dp (
    .tck(tck), .trstN(trstN), .tdi(tdi), .strb(strb),
    .pwrEvent(pwrEvent), .busRdata(busRdata), .tdo(tdo), .pwrCtl(pwrCtl),
    .busStb(busStb), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata)
  );
endmodule

// File: rtl/dbg_jtag_port_chk.sv
module dbg_jtag_port_chk
  import dbg_jtag_pkg::*;
#(
  parameter int PWR_W = 8
) (
  input logic             tck,
  input logic             trstN,
  input logic             tms,
  input logic             tdo,
  input logic             busStb,
  input logic             busWe,
  input logic [PWR_W-1:0] pwrCtl,
  input tapState_e        tapState,
  input logic             phaseData,
  input logic [IR_W-1:0]  irHold
);
  a_r1_five_tms_reset: assert property (@(posedge tck) disable iff (!trstN)
    ($past(tms,1) && $past(tms,2) && $past(tms,3) && $past(tms,4) && $past(tms,5))
      |-> tapState == stTlr);

  a_r11_tdo_quiet: assert property (@(posedge tck) disable iff (!trstN)
    !(tapState == stShDr || tapState == stShIr) |-> !tdo);

  a_r12_stb_pulse: assert property (@(posedge tck) disable iff (!trstN)
    busStb |=> !busStb);

  a_r12_stb_from_update: assert property (@(posedge tck) disable iff (!trstN)
    busStb |-> $past(tapState) == stUpDr && $past(irHold) == OP_REGSEL);

  a_r5_read_from_addr: assert property (@(posedge tck) disable iff (!trstN)
    (busStb && !busWe) |-> !$past(phaseData) && phaseData);

  a_r8_phase_reset: assert property (@(posedge tck) disable iff (!trstN)
    $past(tapState) == stUpIr |-> !phaseData);

  a_r9_pwrctl_only_update: assert property (@(posedge tck) disable iff (!trstN)
    !$stable(pwrCtl) |-> $past(tapState) == stUpDr && $past(irHold) == OP_PWRCTL);
endmodule

bind dbg_jtag_port dbg_jtag_port_chk #(.PWR_W(PWR_W)) i_chk (
  .tck(tck), .trstN(trstN), .tms(tms), .tdo(tdo), .busStb(busStb), .busWe(busWe),
  .pwrCtl(pwrCtl), .tapState(tapState), .phaseData(phaseData), .irHold(irHold)
);

// File: tb/test_dbg_jtag_port.sv
module test_dbg_jtag_port;
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [31:0] ID = 32'h10DE_5A03;

  logic        tck = 1'b0;
  logic        trstN = 1'b0;
  logic        tms = 1'b1;
  logic        tdi = 1'b0;
  logic        tdo;
  logic [7:0]  pwrEvent = '0;
  logic [7:0]  pwrCtl;
  logic        busStb, busWe;
  logic [6:0]  busAddr;
  logic [31:0] busWdata, busRdata;

  logic [31:0] mem [128];
  logic [31:0] expReg [128];
  int          wrCount = 0;
  int          checks = 0;
  int          failures = 0;
  bit          done = 0;

  always #2.5 tck = ~tck;

  dbg_jtag_port #(.IDCODE(ID)) i_dbg_jtag_port (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .tdo(tdo),
    .pwrEvent(pwrEvent), .pwrCtl(pwrCtl), .busStb(busStb), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata)
  );

  assign busRdata = mem[busAddr];

  always @(posedge tck) begin
    if (busStb && busWe) begin
      mem[busAddr] <= busWdata;
      wrCount <= wrCount + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d, output logic o);
    @(negedge tck); #1;
    o = tdo;
    tms = m;
    tdi = d;
  endtask

  task automatic irScan(input logic [4:0] op, output logic [4:0] q);
    logic o;
    tick(1, 0, o); tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    for (int i = 0; i < 5; i++) begin
      tick(i == 4, op[i], o);
      q[i] = o;
    end
    tick(1, 0, o); tick(0, 0, o);
  endtask

  task automatic drScan(input int len, input logic [31:0] din, output logic [31:0] q);
    logic o;
    q = '0;
    tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    for (int i = 0; i < len; i++) begin
      tick(i == len - 1, din[i], o);
      q[i] = o;
    end
    tick(1, 0, o); tick(0, 0, o);
  endtask

  function automatic logic [31:0] bypassOut(input logic [7:0] v);
    return {24'h0, v[6:0], 1'b0};
  endfunction

  task automatic regWrite(input logic [6:0] n, input logic [31:0] v);
    logic [4:0]  q5;
    logic [31:0] q;
    irScan(5'h1C, q5);
    drScan(8, {24'h0, n, 1'b1}, q);
    drScan(32, v, q);
    @(negedge tck); #1;
    check(busStb && busWe && busAddr == n && busWdata == v, "R6 write strobe", busWdata, v);
    expReg[n] = v;
  endtask

  task automatic regRead(input logic [6:0] n, input logic [31:0] din, output logic [31:0] v);
    logic [4:0]  q5;
    logic [31:0] q;
    int          w0;
    irScan(5'h1C, q5);
    drScan(8, {24'h0, n, 1'b0}, q);
    @(negedge tck); #1;
    check(busStb && !busWe && busAddr == n, "R5 read strobe", {busStb, busWe, 23'h0, busAddr}, {2'b10, 23'h0, n});
    @(negedge tck); #1;
    check(!busStb, "R12 strobe one cycle", 32'(busStb), 32'h0);
    w0 = wrCount;
    drScan(32, din, v);
    @(negedge tck); #1;
    check(wrCount == w0, "R7 read scan no write", 32'(wrCount), 32'(w0));
  endtask

  initial begin
    logic [4:0]  q5;
    logic [31:0] q;
    logic        o;
    void'($urandom(32'd1234));
    for (int i = 0; i < 128; i++) begin
      mem[i]    = 32'hA500_0000 | 32'(i * 32'h0001_0203);
      expReg[i] = mem[i];
    end
    repeat (3) @(negedge tck);
    #1;
    check(tdo == 1'b0 && busStb == 1'b0 && pwrCtl == 8'h00, "R9/R11 reset state", {tdo, busStb, 22'h0, pwrCtl}, 32'h0);
    trstN = 1'b1;
    tick(0, 0, o);

    drScan(32, 32'h0, q);
    check(q == ID, "R3 idcode after reset (R1)", q, ID);

    irScan(5'h1F, q5);
    check(q5 == 5'b00001, "R2 IR capture pattern", 32'(q5), 32'h1);
    drScan(8, 32'hB6, q);
    check(q == bypassOut(8'hB6), "R4 bypass 0x1F", q, bypassOut(8'hB6));
    @(negedge tck); #1;
    check(tdo == 1'b0, "R11 tdo idle", 32'(tdo), 32'h0);

    irScan(5'h03, q5);
    drScan(8, 32'h5D, q);
    check(q == bypassOut(8'h5D), "R4 bypass unknown opcode", q, bypassOut(8'h5D));

    repeat (5) tick(1, 0, o);
    tick(0, 0, o);
    drScan(32, 32'h0, q);
    check(q == ID, "R1 five TMS high", q, ID);

    irScan(5'h1F, q5);
    @(negedge tck); #1; trstN = 1'b0;
    @(negedge tck); #1; trstN = 1'b1;
    tick(0, 0, o);
    drScan(32, 32'h0, q);
    check(q == ID, "R1 trst loads idcode", q, ID);

    irScan(5'h08, q5);
    drScan(8, 32'hA5, q);
    check(q == 32'h00, "R9 pwrctl capture reset", q, 32'h0);
    @(negedge tck); #1;
    check(pwrCtl == 8'hA5, "R9 pwrctl update", 32'(pwrCtl), 32'hA5);
    drScan(8, 32'h3C, q);
    check(q == 32'hA5, "R9 pwrctl capture", q, 32'hA5);
    @(negedge tck); #1;
    check(pwrCtl == 8'h3C, "R9 pwrctl second update", 32'(pwrCtl), 32'h3C);

    @(negedge tck); #1; pwrEvent = 8'h0F;
    @(negedge tck); #1; pwrEvent = 8'h00;
    irScan(5'h09, q5);
    drScan(8, 32'h00, q);
    check(q == 32'h0F, "R10 status sticky", q, 32'h0F);
    drScan(8, 32'h05, q);
    check(q == 32'h0F, "R10 status before clear", q, 32'h0F);
    drScan(8, 32'h00, q);
    check(q == 32'h0A, "R10 status after clear", q, 32'h0A);

    regWrite(7'd5, 32'hDEAD_BEEF);
    regRead(7'd5, 32'hFFFF_FFFF, q);
    check(q == 32'hDEAD_BEEF, "R7 read back", q, 32'hDEAD_BEEF);
    regRead(7'd5, 32'h0, q);
    check(q == 32'hDEAD_BEEF, "R7 ignored shift-in", q, 32'hDEAD_BEEF);
    regWrite(7'd127, 32'h0000_0001);
    regRead(7'd127, 32'h1234_5678, q);
    check(q == 32'h1, "R6 top register", q, 32'h1);

    irScan(5'h1C, q5);
    drScan(8, {24'h0, 7'd9, 1'b1}, q);
    irScan(5'h1C, q5);
    drScan(8, {24'h0, 7'd9, 1'b0}, q);
    @(negedge tck); #1;
    check(busStb && !busWe && busAddr == 7'd9, "R8 phase reset on IR load", {busStb, busWe, 23'h0, busAddr}, {2'b10, 23'h0, 7'd9});
    drScan(32, 32'hFFFF_FFFF, q);
    check(q == expReg[9], "R8 data phase after reset", q, expReg[9]);
    drScan(8, {24'h0, 7'd11, 1'b0}, q);
    @(negedge tck); #1;
    check(busStb && !busWe && busAddr == 7'd11, "R8 phase toggles back", {busStb, busWe, 23'h0, busAddr}, {2'b10, 23'h0, 7'd11});
    drScan(32, 32'h0, q);
    check(q == expReg[11], "R8 second read", q, expReg[11]);

    for (int k = 0; k < 24; k++) begin
      logic [6:0]  n;
      logic [31:0] v;
      n = 7'($urandom % 128);
      v = $urandom;
      if ($urandom % 2 == 0) regWrite(n, v);
      else begin
        regRead(n, v, q);
        check(q == expReg[n], "R7 random read", q, expReg[n]);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge tck);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule